// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Datapath

This block is the arithmetic core of a small signal-processing engine. Every clock it takes a 3-bit opcode and two 24-bit signed operands. An operand-load opcode stores the operands in the X and Y latches and registers their 48-bit signed product in P at the same clock edge. The same opcode can also clear the 48-bit accumulator (upper half AH, lower half AL), leave it alone, or add or subtract the product that P already holds. A stream of such opcodes therefore issues one multiply per clock, and each accumulation adds the product of the operands loaded one opcode earlier.

Double-word opcodes work on the accumulator against either P or a spare 48-bit register T. They add or subtract, with an optional carry or borrow input. A compare form sets the flags and leaves the accumulator unchanged. A transfer opcode either exchanges the accumulator with P or T, or copies the accumulator into one of them. Memory addressing and instruction decode stay outside: operands come in on ports, and all state goes out on ports.

Top module: `smac_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, X, Y, P, T and the accumulator are zero and `carry_o` and `zero_o` are 0.
- R2: Opcode 1 (clear-load) stores `a_i` in X and `b_i` in Y, sets P to the signed 48-bit product of `a_i` and `b_i`, and clears the accumulator. All of these change at the same clock edge.
- R3: Opcode 2 (plain load) loads X, Y and P as in R2 and leaves the accumulator unchanged.
- R4: Opcode 3 (load-accumulate) loads X, Y and P as in R2 and sets the accumulator to its old value plus the P value from before the edge, modulo 2^48.
- R5: Opcode 4 (load-deduct) loads X, Y and P as in R2 and sets the accumulator to its old value minus the P value from before the edge, modulo 2^48.
- R6: Opcode 0 changes no register and no flag.
- R7: Opcode 5 adds the source to the accumulator. The source is T when `use_t_i`=1 and P otherwise. When `mod_i[0]`=1 the stored carry flag is also added. `carry_o` becomes the carry out of bit 47, and `zero_o` becomes 1 when the 48-bit result is zero.
- R8: Opcode 6 subtracts the source, chosen as in R7, from the accumulator. When `mod_i[0]`=1 the stored carry flag is also subtracted as a borrow. `carry_o` becomes 1 exactly when the unsigned accumulator is less than the source plus that borrow, and `zero_o` becomes 1 when the result is zero.
- R9: With `mod_i[1]`=1, opcodes 5 and 6 update `carry_o` and `zero_o` as in R7 and R8 and leave the accumulator unchanged (compare).
- R10: Opcode 7 with `mod_i[0]`=1 exchanges the accumulator with the source selected by `use_t_i`.
- R11: Opcode 7 with `mod_i[0]`=0 copies the accumulator into the source selected by `use_t_i` and leaves the accumulator unchanged.
- R12: P changes only on opcodes 1 to 4 and on opcode 7 aimed at P. T changes only on opcode 7 aimed at T. X and Y change only on opcodes 1 to 4. The flags change only on opcodes 5 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Opcode (0 idle, 1 clear-load, 2 load, 3 load-accumulate, 4 load-deduct, 5 add, 6 subtract, 7 transfer) |
| mod_i | input | 2 | Bit 0: use carry (opcodes 5 and 6) or swap (opcode 7); bit 1: compare only |
| use_t_i | input | 1 | Selects T (1) or P (0) as the double-word source or target |
| a_i | input | 24 | Operand for X |
| b_i | input | 24 | Operand for Y |
| x_o | output | 24 | X latch |
| y_o | output | 24 | Y latch |
| p_o | output | 48 | Product register P |
| t_o | output | 48 | Temporary register T |
| acc_o | output | 48 | Accumulator, AH in bits 47:24 and AL in bits 23:0 |
| carry_o | output | 1 | Carry or borrow flag |
| zero_o | output | 1 | Zero-result flag |

## Verification
A directed prologue first loads small positive and negative operand pairs and runs a multiply-accumulate, a multiply-deduct and a clear. These show that each accumulation uses the product of the previous load and not the current one. A long random opcode stream then draws operands from a pool that favours the extreme values 0x800000, 0x7FFFFF, 0xFFFFFF and 0. This covers sign handling in the product and carry or borrow across bit 47. The same stream switches the source between P and T, compare against write, and swap against copy. Any mix-up of source, direction or flag update then shows as a mismatch against the behavioural reference on the very next clock.

// File: rtl/smac_pkg.sv
package smac_pkg;

   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_LDCLR = 3'd1,
      OP_LD    = 3'd2,
      OP_LDACC = 3'd3,
      OP_LDSUB = 3'd4,
      OP_DADD  = 3'd5,
      OP_DSUB  = 3'd6,
      OP_XFER  = 3'd7
   } smac_op_e;

   // bit positions inside mod_i
   localparam int MOD_CARRY = 0;   // use carry (add/sub) or swap (transfer)
   localparam int MOD_CMP   = 1;   // flags only

   function automatic logic is_load(input smac_op_e op);
      return (op == OP_LDCLR) || (op == OP_LD) ||
             (op == OP_LDACC) || (op == OP_LDSUB);
   endfunction

endpackage

// File: rtl/smac_oplatch.sv
module smac_oplatch #(
   parameter int OPW        = 24,
   parameter bit SIGNED_MUL = 1'b1,
   localparam int PW        = 2 * OPW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic [OPW-1:0] a_i,
   input  logic [OPW-1:0] b_i,
   input  logic           p_wr_i,
   input  logic [PW-1:0]  p_wdata_i,
   output logic [OPW-1:0] x_o,
   output logic [OPW-1:0] y_o,
   output logic [PW-1:0]  p_o
);

   if (OPW < 2) begin : g_bad_width
      $error("smac_oplatch: OPW must be at least 2");
   end

   logic [PW-1:0] prod;

   if (SIGNED_MUL) begin : g_signed
      logic signed [PW-1:0] prod_s;
      always_comb prod_s = $signed(a_i) * $signed(b_i);
      assign prod = prod_s;
   end else begin : g_unsigned
      always_comb prod = PW'(a_i) * PW'(b_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_o <= '0;
         y_o <= '0;
         p_o <= '0;
      end else begin
         if (load_i) begin
            x_o <= a_i;
            y_o <= b_i;
         end
         if (p_wr_i)
            p_o <= p_wdata_i;
         else if (load_i)
            p_o <= prod;
      end
   end

   // R2
   xy_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (x_o == $past(a_i)) && (y_o == $past(b_i)));

   // R12
   p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !p_wr_i) |=> $stable(p_o));

endmodule

// File: rtl/smac_dwalu.sv
module smac_dwalu #(
   parameter int W = 48
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         cin_i,
   output logic [W-1:0] res_o,
   output logic         cout_o,
   output logic         zero_o
);

   logic [W:0] wide;

   always_comb begin
      if (sub_i)
         wide = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      else
         wide = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      res_o  = wide[W-1:0];
      cout_o = wide[W];
      zero_o = (wide[W-1:0] == '0);
   end

endmodule

// File: rtl/smac_unit.sv
module smac_unit #(
   parameter int OPW        = 24,
   parameter bit SIGNED_MUL = 1'b1,
   localparam int DW        = 2 * OPW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     op_i,
   input  logic [1:0]     mod_i,
   input  logic           use_t_i,
   input  logic [OPW-1:0] a_i,
   input  logic [OPW-1:0] b_i,
   output logic [OPW-1:0] x_o,
   output logic [OPW-1:0] y_o,
   output logic [DW-1:0]  p_o,
   output logic [DW-1:0]  t_o,
   output logic [DW-1:0]  acc_o,
   output logic           carry_o,
   output logic           zero_o
);
   import smac_pkg::*;

   smac_op_e op;
   assign op = smac_op_e'(op_i);

   logic          load;
   logic          mpy_op;
   logic          dw_op;
   logic          xfer;
   logic          swap;
   logic          cmp_only;
   logic [DW-1:0] dw_src;
   logic [DW-1:0] alu_b;
   logic          alu_sub;
   logic          alu_cin;
   logic [DW-1:0] alu_res;
   logic          alu_cout;
   logic          alu_zero;
   logic          p_wr;
   logic [DW-1:0] p_wdata;

   always_comb begin
      load     = is_load(op);
      mpy_op   = (op == OP_LDACC) || (op == OP_LDSUB);
      dw_op    = (op == OP_DADD) || (op == OP_DSUB);
      xfer     = (op == OP_XFER);
      swap     = mod_i[MOD_CARRY];
      cmp_only = mod_i[MOD_CMP];
      dw_src   = use_t_i ? t_o : p_o;
      alu_b    = mpy_op ? p_o : dw_src;
      alu_sub  = (op == OP_LDSUB) || (op == OP_DSUB);
      alu_cin  = dw_op && mod_i[MOD_CARRY] && carry_o;
      p_wr     = xfer && !use_t_i;
      p_wdata  = acc_o;
   end

   smac_oplatch #(
      .OPW        (OPW),
      .SIGNED_MUL (SIGNED_MUL)
   ) u_oplatch (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .a_i       (a_i),
      .b_i       (b_i),
      .p_wr_i    (p_wr),
      .p_wdata_i (p_wdata),
      .x_o       (x_o),
      .y_o       (y_o),
      .p_o       (p_o)
   );

   smac_dwalu #(
      .W (DW)
   ) u_alu (
      .a_i    (acc_o),
      .b_i    (alu_b),
      .sub_i  (alu_sub),
      .cin_i  (alu_cin),
      .res_o  (alu_res),
      .cout_o (alu_cout),
      .zero_o (alu_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_o   <= '0;
         t_o     <= '0;
         carry_o <= 1'b0;
         zero_o  <= 1'b0;
      end else begin
         unique case (op)
            OP_LDCLR: acc_o <= '0;
            OP_LDACC,
            OP_LDSUB: acc_o <= alu_res;
            OP_DADD,
            OP_DSUB: begin
               carry_o <= alu_cout;
               zero_o  <= alu_zero;
               if (!cmp_only)
                  acc_o <= alu_res;
            end
            OP_XFER: begin
               if (use_t_i)
                  t_o <= acc_o;
               if (swap)
                  acc_o <= dw_src;
            end
            default: ;
         endcase
      end
   end

   // R2
   clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd1) |=> (acc_o == '0));

   // R3
   acc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd2) |=> $stable(acc_o));

   // R4
   mac_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd3) |=> (acc_o == DW'($past(acc_o) + $past(p_o))));

   // R5
   mac_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd4) |=> (acc_o == DW'($past(acc_o) - $past(p_o))));

   // R6
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd0) |=> ($stable(acc_o) && $stable(p_o) && $stable(t_o) &&
                          $stable(carry_o) && $stable(zero_o)));

   // R9
   cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i == 3'd5 || op_i == 3'd6) && mod_i[1]) |=> $stable(acc_o));

   // R10
   swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd7 && mod_i[0] && use_t_i) |=>
         (acc_o == $past(t_o)) && (t_o == $past(acc_o)));

   // R12
   t_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_i == 3'd7 && use_t_i) |=> $stable(t_o));

   // R12
   flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_i == 3'd5 || op_i == 3'd6) |=> ($stable(carry_o) && $stable(zero_o)));

endmodule

// File: tb/smac_unit_test.sv
`timescale 1ns/1ps
module smac_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = '0;
   logic [1:0]  mod_i = '0;
   logic        use_t_i = 1'b0;
   logic [23:0] a_i = '0;
   logic [23:0] b_i = '0;
   logic [23:0] x_o, y_o;
   logic [47:0] p_o, t_o, acc_o;
   logic        carry_o, zero_o;

   always #2.5 clk = ~clk;

   smac_unit uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .mod_i(mod_i), .use_t_i(use_t_i),
      .a_i(a_i), .b_i(b_i), .x_o(x_o), .y_o(y_o), .p_o(p_o), .t_o(t_o),
      .acc_o(acc_o), .carry_o(carry_o), .zero_o(zero_o)
   );

   int checks = 0;
   int errors = 0;

   // reference state
   logic [23:0] mx, my;
   logic [47:0] mp, mt, macc;
   logic        mc, mz;

   task automatic chk(input string req, input string what,
                      input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] op, input logic [1:0] md);
      case (op)
         3'd0: return "R6";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         3'd5: return md[1] ? "R9" : "R7";
         3'd6: return md[1] ? "R9" : "R8";
         default: return md[0] ? "R10" : "R11";
      endcase
   endfunction

   function automatic logic [47:0] sprod(input logic [23:0] a, input logic [23:0] b);
      longint sa, sb;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 48'(sa * sb);
   endfunction

   task automatic model(input logic [2:0] op, input logic [1:0] md,
                        input logic ut, input logic [23:0] a, input logic [23:0] b);
      logic [47:0] src, res;
      logic [48:0] w;
      logic        ci;
      src = ut ? mt : mp;
      ci  = md[0] ? mc : 1'b0;
      case (op)
         3'd1, 3'd2, 3'd3, 3'd4: begin
            if (op == 3'd1) macc = '0;
            if (op == 3'd3) macc = macc + mp;
            if (op == 3'd4) macc = macc - mp;
            mx = a; my = b; mp = sprod(a, b);
         end
         3'd5: begin
            w = 49'(macc) + 49'(src) + 49'(ci);
            res = w[47:0]; mc = w[48]; mz = (res == 0);
            if (!md[1]) macc = res;
         end
         3'd6: begin
            res = macc - src - 48'(ci);
            mc = (49'(macc) < 49'(src) + 49'(ci));
            mz = (res == 0);
            if (!md[1]) macc = res;
         end
         3'd7: begin
            res = macc;
            if (md[0]) macc = src;
            if (ut) mt = res; else mp = res;
         end
         default: ;
      endcase
   endtask

   task automatic compare_all(input string req);
      chk(req, "acc", acc_o, macc);
      chk(req, "x", 48'(x_o), 48'(mx));
      chk(req, "y", 48'(y_o), 48'(my));
      chk("R12", "p", p_o, mp);
      chk("R12", "t", t_o, mt);
      chk(req, "flags", 48'({carry_o, zero_o}), 48'({mc, mz}));
   endtask

   task automatic step(input logic [2:0] op, input logic [1:0] md,
                       input logic ut, input logic [23:0] a, input logic [23:0] b);
      op_i = op; mod_i = md; use_t_i = ut; a_i = a; b_i = b;
      model(op, md, ut, a, b);
      @(negedge clk);
      compare_all(tag_of(op, md));
   endtask

   function automatic logic [23:0] pick(input int unsigned r);
      case (r % 8)
         0: return 24'h800000;
         1: return 24'h7FFFFF;
         2: return 24'hFFFFFF;
         3: return 24'h000000;
         default: return 24'($urandom);
      endcase
   endfunction

   initial begin
      mx = '0; my = '0; mp = '0; mt = '0; macc = '0; mc = 1'b0; mz = 1'b0;
      repeat (3) @(negedge clk);
      compare_all("R1");           // R1 while held in reset
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1");           // R1 after release with idle opcode

      // R2/R4/R5: accumulate uses the previously loaded product
      step(3'd1, 2'b00, 1'b0, 24'd3, 24'd5);
      step(3'd3, 2'b00, 1'b0, 24'hFFFFFE, 24'd7);   // acc = 15
      step(3'd4, 2'b00, 1'b0, 24'd2, 24'd2);        // acc = 15 - (-14)
      step(3'd2, 2'b00, 1'b0, 24'h800000, 24'h800000); // R3
      step(3'd0, 2'b00, 1'b0, 24'd9, 24'd9);        // R6
      step(3'd7, 2'b00, 1'b1, 24'd0, 24'd0);        // R11 copy to T
      step(3'd6, 2'b10, 1'b1, 24'd0, 24'd0);        // R9 compare equal -> zero
      step(3'd5, 2'b00, 1'b0, 24'd0, 24'd0);        // R7 add P
      step(3'd7, 2'b01, 1'b0, 24'd0, 24'd0);        // R10 swap with P
      step(3'd6, 2'b01, 1'b1, 24'd0, 24'd0);        // R8 sub T with borrow
      step(3'd1, 2'b00, 1'b0, 24'h7FFFFF, 24'h7FFFFF); // R2

      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r = $urandom;
         step(3'(r), 2'(r >> 3), r[5], pick($urandom), pick($urandom));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule